// File: doc/BRIEF.md
# Interrupt Priority Level Recognizer

This block sits between a set of active-low, level-sensitive interrupt request lines and a processor core. Request line `k` carries priority level `k+1`. Level 0 means that nothing is requested. Every line first passes through a multi-stage synchronizer. The synchronized lines are then priority-encoded. The result is compared against the 3-bit priority mask taken from the core's status register. The outcome is registered as a pending level and a valid flag.

The highest level is treated as non-maskable. It is recognized even when the mask holds its largest value. All other levels must be strictly above the mask to be recognized.

The core answers a recognized request with a one-cycle acknowledge strobe that carries the level being serviced. If that level matches the pending level, the block pulses a hit flag together with the acknowledged level, so the requester can release its line. Any other acknowledge is flagged as spurious. Because the request inputs are level sensitive, a request stays reported for as long as its line is held low.

Top module: `irq_level_recognizer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `pend_vld`, `pend_lvl`, `ack_hit`, `ack_hit_lvl` and `ack_spur` all at zero.
- R2: A change on `irq_req_n` reaches `pend_lvl`/`pend_vld` after exactly three rising edges: two synchronizer stages and one output register. It is not visible after two edges.
- R3: Bit `k` of `irq_req_n` (0..6) requests level `k+1`. When several bits are low, `pend_lvl` equals the highest requested level.
- R4: A level from 1 to 6 is reported (`pend_vld`=1) only when it is strictly greater than `ipl_mask`, where `ipl_mask` is sampled at the same edge as the output register. A level less than or equal to the mask gives `pend_vld`=0.
- R5: Level 7 gives `pend_vld`=1 for every mask value, including 7.
- R6: Whenever `pend_vld` is 0, `pend_lvl` is 0.
- R7: A line held low keeps its level reported for as long as it stays low and no higher line is active. Three edges after the line is released, the report is gone.
- R8: If `ack_stb` is 1 at an edge where `pend_vld` is 1 and `ack_lvl` equals `pend_lvl`, then the next cycle shows `ack_hit`=1, `ack_hit_lvl`=`ack_lvl` and `ack_spur`=0, for one cycle only.
- R9: If `ack_stb` is 1 at an edge where `pend_vld` is 0, or where `ack_lvl` differs from `pend_lvl`, then the next cycle shows `ack_spur`=1, `ack_hit`=0 and `ack_hit_lvl`=0.
- R10: If `ack_stb` is 0 at an edge, then `ack_hit` and `ack_spur` are both 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req_n | input | 7 | Request lines, active low; bit k is level k+1 |
| ipl_mask | input | 3 | Priority mask from the status register |
| ack_stb | input | 1 | One-cycle acknowledge strobe |
| ack_lvl | input | 3 | Level being acknowledged |
| pend_lvl | output | 3 | Registered pending level, 0 when none |
| pend_vld | output | 1 | Pending level is recognized |
| ack_hit | output | 1 | Acknowledge matched the pending level |
| ack_hit_lvl | output | 3 | Level that was acknowledged, 0 otherwise |
| ack_spur | output | 1 | Acknowledge did not match a pending level |

## Verification
Two functions can fall in the same cycle: an acknowledge is judged and, at that same edge, the pending register moves to a new level. The bench provokes this by pulling a higher line low. It then times the strobe so that it is sampled at exactly the edge where the higher level lands. An acknowledge that names the old level must count as a hit while `pend_lvl` moves on. An acknowledge that names the new level must count as spurious. The ordinary function is swept over all 128 line patterns against all 8 mask values.

// File: rtl/irq_rec_pkg.sv
package irq_rec_pkg;
   localparam int DEF_LEVELS = 7;
   localparam int DEF_SYNC   = 2;

   function automatic int lvl_width(input int levels);
      return $clog2(levels + 1);
   endfunction
endpackage

// File: rtl/irq_sync_bank.sv
module irq_sync_bank #(
   parameter int LINES  = 7,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] req_n_async,
   output logic [LINES-1:0] req_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irq_sync_bank: STAGES must be at least 2");
   end

   for (genvar ln = 0; ln < LINES; ln++) begin : g_line
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            chain <= '0;
         end else begin
            chain <= {chain[STAGES-2:0], ~req_n_async[ln]};
         end
      end
      assign req_sync[ln] = chain[STAGES-1];
   end
endmodule

// File: rtl/irq_prio_encode.sv
module irq_prio_encode #(
   parameter int LINES = 7,
   parameter int LVL_W = 3
) (
   input  logic [LINES-1:0] req,
   output logic [LVL_W-1:0] level
);
   always_comb begin
      level = '0;
      for (int i = 0; i < LINES; i++) begin
         if (req[i]) level = LVL_W'(i + 1);
      end
   end
endmodule

// File: rtl/irq_mask_gate.sv
module irq_mask_gate #(
   parameter int LEVELS  = 7,
   parameter int LVL_W   = 3,
   parameter bit TOP_NMI = 1'b1
) (
   input  logic [LVL_W-1:0] level,
   input  logic [LVL_W-1:0] mask,
   output logic             recog
);
   localparam logic [LVL_W-1:0] TOP = LVL_W'(LEVELS);

   if (TOP_NMI) begin : g_nmi
      assign recog = (level > mask) || (level == TOP);
   end else begin : g_plain
      assign recog = (level > mask);
   end
endmodule

// File: rtl/irq_ack_track.sv
module irq_ack_track #(
   parameter int LVL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ack_stb,
   input  logic [LVL_W-1:0] ack_lvl,
   input  logic [LVL_W-1:0] cur_lvl,
   input  logic             cur_vld,
   output logic             hit,
   output logic [LVL_W-1:0] hit_lvl,
   output logic             spur
);
   logic match;
   assign match = cur_vld && (ack_lvl == cur_lvl);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hit     <= 1'b0;
         hit_lvl <= '0;
         spur    <= 1'b0;
      end else begin
         hit     <= ack_stb && match;
         hit_lvl <= (ack_stb && match) ? ack_lvl : '0;
         spur    <= ack_stb && !match;
      end
   end
endmodule

// File: rtl/irq_level_recognizer.sv
module irq_level_recognizer
   import irq_rec_pkg::*;
#(
   parameter int NUM_LEVELS  = DEF_LEVELS,
   parameter int SYNC_STAGES = DEF_SYNC,
   parameter bit TOP_NMI     = 1'b1,
   localparam int LVL_W      = lvl_width(NUM_LEVELS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_LEVELS-1:0] irq_req_n,
   input  logic [LVL_W-1:0]      ipl_mask,
   input  logic                  ack_stb,
   input  logic [LVL_W-1:0]      ack_lvl,
   output logic [LVL_W-1:0]      pend_lvl,
   output logic                  pend_vld,
   output logic                  ack_hit,
   output logic [LVL_W-1:0]      ack_hit_lvl,
   output logic                  ack_spur
);
   if (NUM_LEVELS < 1) begin : g_bad_levels
      $error("irq_level_recognizer: NUM_LEVELS must be at least 1");
   end

   logic [NUM_LEVELS-1:0] req_s;
   logic [LVL_W-1:0]      enc_lvl;
   logic                  enc_ok;

   irq_sync_bank #(.LINES(NUM_LEVELS), .STAGES(SYNC_STAGES)) sync_i (
      .clk(clk), .rst_n(rst_n), .req_n_async(irq_req_n), .req_sync(req_s)
   );

   irq_prio_encode #(.LINES(NUM_LEVELS), .LVL_W(LVL_W)) enc_i (
      .req(req_s), .level(enc_lvl)
   );

   irq_mask_gate #(.LEVELS(NUM_LEVELS), .LVL_W(LVL_W), .TOP_NMI(TOP_NMI)) gate_i (
      .level(enc_lvl), .mask(ipl_mask), .recog(enc_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_lvl <= '0;
         pend_vld <= 1'b0;
      end else begin
         pend_vld <= enc_ok;
         pend_lvl <= enc_ok ? enc_lvl : '0;
      end
   end

   irq_ack_track #(.LVL_W(LVL_W)) ack_i (
      .clk(clk), .rst_n(rst_n), .ack_stb(ack_stb), .ack_lvl(ack_lvl),
      .cur_lvl(pend_lvl), .cur_vld(pend_vld),
      .hit(ack_hit), .hit_lvl(ack_hit_lvl), .spur(ack_spur)
   );
endmodule

// File: rtl/irq_level_recognizer_chk.sv
module irq_level_recognizer_chk #(
   parameter int NUM_LEVELS = 7,
   parameter int LVL_W      = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [LVL_W-1:0] ipl_mask,
   input logic             ack_stb,
   input logic [LVL_W-1:0] ack_lvl,
   input logic [LVL_W-1:0] pend_lvl,
   input logic             pend_vld,
   input logic             ack_hit,
   input logic [LVL_W-1:0] ack_hit_lvl,
   input logic             ack_spur
);
   localparam logic [LVL_W-1:0] TOP = LVL_W'(NUM_LEVELS);

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (!pend_vld && pend_lvl == '0 && !ack_hit && !ack_spur && ack_hit_lvl == '0));

   // R4
   mask_respect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_vld && pend_lvl != TOP) |-> (pend_lvl > $past(ipl_mask)));

   // R6
   zero_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_vld |-> (pend_lvl == '0));

   // R8
   ack_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_stb && pend_vld && ack_lvl == pend_lvl) |=> (ack_hit && !ack_spur && ack_hit_lvl == $past(ack_lvl)));

   // R9
   ack_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_stb && !(pend_vld && ack_lvl == pend_lvl)) |=> (ack_spur && !ack_hit && ack_hit_lvl == '0));

   // R10
   ack_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_stb |=> (!ack_hit && !ack_spur));
endmodule

bind irq_level_recognizer irq_level_recognizer_chk #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .ipl_mask(ipl_mask), .ack_stb(ack_stb), .ack_lvl(ack_lvl),
   .pend_lvl(pend_lvl), .pend_vld(pend_vld), .ack_hit(ack_hit),
   .ack_hit_lvl(ack_hit_lvl), .ack_spur(ack_spur)
);

// File: tb/irq_level_recognizer_tb_top.sv
module irq_level_recognizer_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] irq_req_n = 7'h7f;
   logic [2:0] ipl_mask = 3'd0;
   logic       ack_stb = 1'b0;
   logic [2:0] ack_lvl = 3'd0;
   logic [2:0] pend_lvl;
   logic       pend_vld;
   logic       ack_hit;
   logic [2:0] ack_hit_lvl;
   logic       ack_spur;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irq_level_recognizer dut_i (
      .clk(clk), .rst_n(rst_n), .irq_req_n(irq_req_n), .ipl_mask(ipl_mask),
      .ack_stb(ack_stb), .ack_lvl(ack_lvl), .pend_lvl(pend_lvl), .pend_vld(pend_vld),
      .ack_hit(ack_hit), .ack_hit_lvl(ack_hit_lvl), .ack_spur(ack_spur)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic edges(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   function automatic int top_level(input int pat);
      int l = 0;
      for (int i = 0; i < 7; i++) if (pat[i]) l = i + 1;
      return l;
   endfunction

   function automatic int exp_valid(input int lvl, input int mask);
      return (lvl != 0 && (lvl > mask || lvl == 7)) ? 1 : 0;
   endfunction

   initial begin
      #200000;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      edges(3);
      // R1 reset state
      check("R1 pend_vld", int'(pend_vld), 0);
      check("R1 pend_lvl", int'(pend_lvl), 0);
      check("R1 ack_hit", int'(ack_hit), 0);
      check("R1 ack_spur", int'(ack_spur), 0);
      rst_n = 1'b1;
      edges(4);

      // R2 latency: level 4 with mask 0
      irq_req_n = 7'b111_0111;
      edges(2);
      check("R2 not after two edges", int'(pend_vld), 0);
      edges(1);
      check("R2 after three edges vld", int'(pend_vld), 1);
      check("R2 after three edges lvl", int'(pend_lvl), 4);

      // R7 held, then released
      edges(10);
      check("R7 still held", int'(pend_lvl), 4);
      irq_req_n = 7'h7f;
      edges(2);
      check("R7 held two edges after release", int'(pend_lvl), 4);
      edges(1);
      check("R7 cleared three edges after release", int'(pend_vld), 0);

      // R3 R4 R5 R6 sweep
      for (int m = 0; m < 8; m++) begin
         for (int p = 0; p < 128; p++) begin
            int lv;
            int ev;
            ipl_mask = 3'(m);
            irq_req_n = ~7'(p);
            edges(3);
            lv = top_level(p);
            ev = exp_valid(lv, m);
            if (lv == 7) check("R5 top level vld", int'(pend_vld), 1);
            else         check("R4 mask vld", int'(pend_vld), ev);
            if (ev == 1) check("R3 highest level", int'(pend_lvl), lv);
            else         check("R6 lvl zero when idle", int'(pend_lvl), 0);
         end
      end

      // R8 matching acknowledge
      ipl_mask = 3'd1;
      irq_req_n = 7'b111_1011;   // level 3
      edges(4);
      ack_lvl = 3'd3; ack_stb = 1'b1;
      edges(1);
      ack_stb = 1'b0;
      check("R8 hit", int'(ack_hit), 1);
      check("R8 hit level", int'(ack_hit_lvl), 3);
      check("R8 no spur", int'(ack_spur), 0);
      edges(1);
      check("R8 one cycle only", int'(ack_hit), 0);
      check("R10 quiet spur", int'(ack_spur), 0);

      // R9 wrong level
      ack_lvl = 3'd2; ack_stb = 1'b1;
      edges(1);
      ack_stb = 1'b0;
      check("R9 wrong level spur", int'(ack_spur), 1);
      check("R9 wrong level no hit", int'(ack_hit), 0);
      check("R9 hit level zero", int'(ack_hit_lvl), 0);

      // Same-cycle: ack of old level while pending moves to 5
      irq_req_n = 7'b110_1011;   // levels 3 and 5
      edges(2);
      ack_lvl = 3'd3; ack_stb = 1'b1;
      edges(1);
      ack_stb = 1'b0;
      check("R8 hit on old level at change", int'(ack_hit), 1);
      check("R8 old level reported", int'(ack_hit_lvl), 3);
      check("R3 pending moved to 5", int'(pend_lvl), 5);

      // Same-cycle: ack naming new level before it lands
      irq_req_n = 7'b010_1011;   // add level 7
      edges(2);
      ack_lvl = 3'd7; ack_stb = 1'b1;
      edges(1);
      ack_stb = 1'b0;
      check("R9 early ack of new level spur", int'(ack_spur), 1);
      check("R5 pending now 7", int'(pend_lvl), 7);

      // R9 ack while nothing pending; masked level 2
      ipl_mask = 3'd6;
      irq_req_n = 7'b111_1101;
      edges(4);
      check("R4 masked level idle", int'(pend_vld), 0);
      ack_lvl = 3'd0; ack_stb = 1'b1;
      edges(1);
      ack_stb = 1'b0;
      check("R9 ack with nothing pending", int'(ack_spur), 1);
      check("R9 ack with nothing pending hit", int'(ack_hit), 0);

      // R10 no strobe, level present
      ipl_mask = 3'd0;
      ack_lvl = 3'd2;
      edges(4);
      check("R10 no strobe no hit", int'(ack_hit), 0);
      check("R10 no strobe no spur", int'(ack_spur), 0);

      // R1 reset mid-run
      rst_n = 1'b0;
      edges(1);
      check("R1 reset clears vld", int'(pend_vld), 0);
      check("R1 reset clears lvl", int'(pend_lvl), 0);
      rst_n = 1'b1;
      edges(2);
      check("R2 after reset two edges", int'(pend_vld), 0);
      edges(1);
      check("R2 after reset three edges", int'(pend_lvl), 2);

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule